// File: doc/BRIEF.md
# Eight-Level Interrupt Priority Resolver

This block looks at eight interrupt request lines, holds which of them are pending and which are being serviced, and decides whether a single interrupt line to the processor should be raised. When it is raised, the block names the winning level. When the processor acknowledges, that level moves into service. An end-of-interrupt strobe then retires the most urgent level in service.

The order among the levels comes from one of four modes. In fixed order, line 0 ranks first. The special nested mode is for a master that has a slave controller on one of its inputs: it lets a request at the same rank as the level in service through. In automatic rotation, each retired level drops to last place. In programmed rotation, the last place is taken from an input. Every line can be masked on its own. Every line can be chosen to act on a rising edge or on its level.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `irq_o` is low, `isr_o` and `irr_o` are zero, the mode-2 rotation base is 0, and the edge-detect history is zero.
- R2: For a line whose `lvl_sens_i` bit is 0, a rising edge latches its `irr_o` bit on the next clock, and the bit stays set after the line falls until that level is acknowledged. For a line whose bit is 1, its `irr_o` bit follows the line with one cycle of delay.
- R3: A pending level whose `mask_i` bit is 1 never wins and never raises `irq_o`. Its `irr_o` bit is kept.
- R4: The winner is the unmasked pending level that comes first in the current order. Its number appears on `win_o`. In mode 0 (`mode_i`=0) the order is 0,1,...,7.
- R5: In modes 0, 2 and 3, `irq_o` is high only when an unmasked level is pending and either nothing is in service or the winner ranks strictly ahead of the first in-service level.
- R6: In mode 1 (special nested, order 0..7), `irq_o` is also high when the winner ranks equal to the first in-service level.
- R7: `ack_i` while `irq_o` is high sets the `isr_o` bit of `win_o` and clears that level's edge-latched `irr_o` bit on the next clock. `ack_i` while `irq_o` is low has no effect.
- R8: `eoi_i` clears the `isr_o` bit that comes first in the current order. If `ack_i` is accepted in the same cycle, its set is applied after the clear.
- R9: In mode 2 (automatic rotation), `eoi_i` retiring level L makes L+1 (mod 8) the first level and L the last, for the following cycles.
- R10: In mode 3 (programmed rotation), level `low_lvl_i` ranks last and `low_lvl_i`+1 (mod 8) ranks first. The order changes in the same cycle as `low_lvl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines |
| lvl_sens_i | input | 8 | Per line: 1 = level sensitive, 0 = rising edge |
| mask_i | input | 8 | Per level: 1 = masked |
| mode_i | input | 2 | 0 fixed, 1 special nested, 2 automatic rotation, 3 programmed rotation |
| low_lvl_i | input | 3 | Level ranked last in mode 3 |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| irq_o | output | 1 | Interrupt to the processor |
| win_o | output | 3 | Winning level number, meaningful while `irq_o` is high |
| isr_o | output | 8 | In-service register |
| irr_o | output | 8 | Request register |

## Verification
A wrong in-service bit or a wrong rotation base has no register of its own at the ports. It shows up as a wrong `irq_o` or `win_o` in the first cycle in which a competing request is pending. It also shows up on `isr_o` one clock after the next end-of-interrupt clears the wrong bit. A request latch that misses an edge or clears too early shows on `irr_o` one clock later, and on `irq_o` in the same cycle as `irr_o`. The bench keeps its own model of both registers and of the base, and compares every output after every clock, so a divergence is reported in the cycle where it first becomes visible.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // width of a level number; the level count is 2**LVL_W
  localparam int LVL_W = 3;

  // ordering modes
  localparam logic [1:0] MODE_FIXED   = 2'd0;
  localparam logic [1:0] MODE_SPECIAL = 2'd1;
  localparam logic [1:0] MODE_AUTO    = 2'd2;
  localparam logic [1:0] MODE_PROG    = 2'd3;
endpackage

// File: rtl/irq_prio_pick.sv
// Finds the first set bit of a vector, walking upward from a base level
// with wrap-around, and reports its level and its rank relative to the base.
module irq_prio_pick #(
  parameter int LVW = 3,
  localparam int N = 1 << LVW
) (
  input  logic [N-1:0]   vec_i,
  input  logic [LVW-1:0] base_i,
  output logic           any_o,
  output logic [LVW-1:0] lvl_o,
  output logic [LVW-1:0] rank_o
);
  function automatic logic [LVW-1:0] lvl_at_rank(logic [LVW-1:0] base, logic [LVW-1:0] rank);
    return base + rank;
  endfunction

  always_comb begin
    any_o  = 1'b0;
    rank_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[lvl_at_rank(base_i, LVW'(k))]) begin
        any_o  = 1'b1;
        rank_o = LVW'(k);
      end
    end
    lvl_o = lvl_at_rank(base_i, rank_o);
  end
endmodule

// File: rtl/irq_req_latch.sv
// Request register: edge-latched or level-following per line.
module irq_req_latch #(
  parameter int LVW = 3,
  localparam int N = 1 << LVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] lvl_sens_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_q;
  logic [N-1:0] rise;

  assign rise  = req_i & ~prev_q;
  assign irr_o = irr_q;

  for (genvar g = 0; g < N; g++) begin : gen_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        irr_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        if (lvl_sens_i[g])
          irr_q[g] <= req_i[g];
        else
          irr_q[g] <= (irr_q[g] | rise[g]) & ~clr_i[g];
      end
    end
  end
endmodule

// File: rtl/irq_service_reg.sv
// In-service register and the automatic-rotation base.
module irq_service_reg #(
  parameter int LVW = 3,
  localparam int N = 1 << LVW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   set_i,
  input  logic           eoi_i,
  input  logic [LVW-1:0] eoi_lvl_i,
  input  logic           adv_base_i,
  output logic [N-1:0]   isr_o,
  output logic [LVW-1:0] rot_o
);
  function automatic logic [N-1:0] lvl_onehot(logic [LVW-1:0] l);
    return {{(N-1){1'b0}}, 1'b1} << l;
  endfunction

  function automatic logic [LVW-1:0] after_lvl(logic [LVW-1:0] l);
    return l + 1'b1;
  endfunction

  logic [N-1:0]   isr_q;
  logic [LVW-1:0] rot_q;
  logic [N-1:0]   clr_vec;

  assign clr_vec = eoi_i ? lvl_onehot(eoi_lvl_i) : '0;
  assign isr_o   = isr_q;
  assign rot_o   = rot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      rot_q <= '0;
    end else begin
      isr_q <= (isr_q & ~clr_vec) | set_i;
      if (adv_base_i)
        rot_q <= after_lvl(eoi_lvl_i);
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int LVW = LVL_W,
  localparam int N = 1 << LVW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_i,
  input  logic [N-1:0]   lvl_sens_i,
  input  logic [N-1:0]   mask_i,
  input  logic [1:0]     mode_i,
  input  logic [LVW-1:0] low_lvl_i,
  input  logic           ack_i,
  input  logic           eoi_i,
  output logic           irq_o,
  output logic [LVW-1:0] win_o,
  output logic [N-1:0]   isr_o,
  output logic [N-1:0]   irr_o
);
  function automatic logic [LVW-1:0] base_for_mode(logic [1:0] mode, logic [LVW-1:0] rot,
                                                   logic [LVW-1:0] low);
    case (mode)
      MODE_AUTO: return rot;
      MODE_PROG: return low + 1'b1;
      default:   return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] lvl_onehot(logic [LVW-1:0] l);
    return {{(N-1){1'b0}}, 1'b1} << l;
  endfunction

  // named internal events
  logic [LVW-1:0] rot_base;
  logic [LVW-1:0] eff_base;
  logic [N-1:0]   cand;
  logic           cand_any;
  logic [LVW-1:0] win_lvl;
  logic [LVW-1:0] win_rank;
  logic           svc_any;
  logic [LVW-1:0] svc_lvl;
  logic [LVW-1:0] svc_rank;
  logic           ahead;
  logic           ack_take;
  logic           eoi_take;
  logic           auto_adv;
  logic [N-1:0]   ack_vec;

  assign eff_base = base_for_mode(mode_i, rot_base, low_lvl_i);
  assign cand     = irr_o & ~mask_i;

  irq_prio_pick #(.LVW(LVW)) u_pick_req (
    .vec_i  (cand),
    .base_i (eff_base),
    .any_o  (cand_any),
    .lvl_o  (win_lvl),
    .rank_o (win_rank)
  );

  irq_prio_pick #(.LVW(LVW)) u_pick_svc (
    .vec_i  (isr_o),
    .base_i (eff_base),
    .any_o  (svc_any),
    .lvl_o  (svc_lvl),
    .rank_o (svc_rank)
  );

  assign ahead    = (mode_i == MODE_SPECIAL) ? (win_rank <= svc_rank) : (win_rank < svc_rank);
  assign irq_o    = cand_any && (!svc_any || ahead);
  assign win_o    = win_lvl;
  assign ack_take = ack_i && irq_o;
  assign ack_vec  = ack_take ? lvl_onehot(win_lvl) : '0;
  assign eoi_take = eoi_i && svc_any;
  assign auto_adv = eoi_take && (mode_i == MODE_AUTO);

  irq_req_latch #(.LVW(LVW)) u_irr (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .lvl_sens_i (lvl_sens_i),
    .clr_i      (ack_vec),
    .irr_o      (irr_o)
  );

  irq_service_reg #(.LVW(LVW)) u_isr (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (ack_vec),
    .eoi_i      (eoi_take),
    .eoi_lvl_i  (svc_lvl),
    .adv_base_i (auto_adv),
    .isr_o      (isr_o),
    .rot_o      (rot_base)
  );
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
  parameter int LVW = 3,
  localparam int N = 1 << LVW
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   mask_i,
  input logic [1:0]     mode_i,
  input logic           ack_i,
  input logic           eoi_i,
  input logic           irq_o,
  input logic [LVW-1:0] win_o,
  input logic [N-1:0]   isr_o,
  input logic [N-1:0]   irr_o,
  input logic           ack_take,
  input logic           eoi_take,
  input logic [LVW-1:0] eoi_lvl,
  input logic [LVW-1:0] rot_base
);
  assert_masked_never_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_i[win_o]);

  assert_winner_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irr_o[win_o]);

  assert_fixed_zero_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && irq_o && irr_o[0] && !mask_i[0]) |-> win_o == '0);

  assert_idle_grants_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_o == '0 && (irr_o & ~mask_i) != '0) |-> irq_o);

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> isr_o[$past(win_o)]);

  assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> isr_o == $past(isr_o));

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_take && !ack_take) |=> $countones(isr_o) == $countones($past(isr_o)) - 1);

  assert_auto_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && eoi_take) |=> rot_base == LVW'($past(eoi_lvl) + 1'b1));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.LVW(LVW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mask_i   (mask_i),
  .mode_i   (mode_i),
  .ack_i    (ack_i),
  .eoi_i    (eoi_i),
  .irq_o    (irq_o),
  .win_o    (win_o),
  .isr_o    (isr_o),
  .irr_o    (irr_o),
  .ack_take (ack_take),
  .eoi_take (eoi_take),
  .eoi_lvl  (svc_lvl),
  .rot_base (rot_base)
);

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i, lvl_sens_i, mask_i;
  logic [1:0] mode_i;
  logic [2:0] low_lvl_i;
  logic       ack_i, eoi_i;
  logic       irq_o;
  logic [2:0] win_o;
  logic [7:0] isr_o, irr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_irr, m_isr, m_prev;
  int         m_rot;

  irq_prio_resolver i_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lvl_sens_i(lvl_sens_i),
    .mask_i(mask_i), .mode_i(mode_i), .low_lvl_i(low_lvl_i), .ack_i(ack_i),
    .eoi_i(eoi_i), .irq_o(irq_o), .win_o(win_o), .isr_o(isr_o), .irr_o(irr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // first level from the base: returns its position in the order, or -1
  function automatic int pos_first(logic [7:0] v, int base);
    for (int k = 0; k < 8; k++)
      if (v[(base + k) % 8]) return k;
    return -1;
  endfunction

  function automatic int cur_base();
    if (mode_i == 2'd2) return m_rot;
    if (mode_i == 2'd3) return (int'(low_lvl_i) + 1) % 8;
    return 0;
  endfunction

  function automatic bit exp_irq();
    int b  = cur_base();
    int pw = pos_first(m_irr & ~mask_i, b);
    int ps = pos_first(m_isr, b);
    if (pw < 0) return 0;
    if (ps < 0) return 1;
    if (mode_i == 2'd1) return pw <= ps;
    return pw < ps;
  endfunction

  function automatic int exp_win();
    int b = cur_base();
    return (b + pos_first(m_irr & ~mask_i, b)) % 8;
  endfunction

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_prev = '0; m_rot = 0;
  endtask

  // one clock: predict, advance, compare every output against the model
  task automatic tick();
    logic [7:0] n_irr, n_isr;
    int   n_rot, b, w, ps;
    bit   acc;
    b   = cur_base();
    acc = ack_i && exp_irq();
    w   = exp_win();
    ps  = pos_first(m_isr, b);
    n_isr = m_isr;
    n_rot = m_rot;
    if (eoi_i && ps >= 0) begin
      n_isr[(b + ps) % 8] = 1'b0;
      if (mode_i == 2'd2) n_rot = (b + ps + 1) % 8;
    end
    if (acc) n_isr[w] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (lvl_sens_i[i]) n_irr[i] = req_i[i];
      else n_irr[i] = (m_irr[i] | (req_i[i] & ~m_prev[i])) & ~(acc && w == i);
    end
    @(posedge clk);
    #1;
    m_irr = n_irr; m_isr = n_isr; m_rot = n_rot; m_prev = req_i;
    chk("R5 irq", int'(irq_o), int'(exp_irq()));
    if (exp_irq()) chk("R4 winner", int'(win_o), exp_win());
    chk("R7/R8 isr", int'(isr_o), int'(m_isr));
    chk("R2 irr", int'(irr_o), int'(m_irr));
  endtask

  task automatic pulse_ack();
    ack_i = 1; tick(); ack_i = 0;
  endtask

  task automatic pulse_eoi();
    eoi_i = 1; tick(); eoi_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_i = 0; lvl_sens_i = 0; mask_i = 0; mode_i = 0;
    low_lvl_i = 0; ack_i = 0; eoi_i = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 isr", int'(isr_o), 0);
    chk("R1 irr", int'(irr_o), 0);
    rst_n = 1;

    // R2: edge latch holds after line falls; level line follows
    req_i = 8'h08; tick();
    chk("R2 edge latched", int'(irr_o), 8'h08);
    req_i = 8'h00; tick();
    chk("R2 edge held", int'(irr_o), 8'h08);
    lvl_sens_i = 8'h40; req_i = 8'h40; tick();
    chk("R2 level set", int'(irr_o[6]), 1);
    req_i = 8'h00; tick();
    chk("R2 level follows", int'(irr_o[6]), 0);
    lvl_sens_i = 8'h00;
    chk("R4 fixed winner", int'(win_o), 3);

    // R7: acknowledge moves level 3 into service
    pulse_ack();
    chk("R7 isr set", int'(isr_o), 8'h08);
    chk("R7 irr cleared", int'(irr_o), 8'h00);

    // R5: lower level blocked, higher level passes
    req_i = 8'h20; tick();
    chk("R5 lower blocked", int'(irq_o), 0);
    req_i = 8'h22; tick();
    chk("R5 higher passes", int'(irq_o), 1);
    chk("R4 winner 1", int'(win_o), 1);
    pulse_ack();
    // R8: EOI retires level 1 (first in order) and keeps 3
    pulse_eoi();
    chk("R8 first retired", int'(isr_o), 8'h08);
    pulse_eoi();
    chk("R8 empty", int'(isr_o), 8'h00);
    pulse_ack(); pulse_eoi();      // drain level 5
    req_i = 8'h00; tick();

    // R6: same level re-requests while in service
    req_i = 8'h08; tick();
    pulse_ack();
    req_i = 8'h00; tick();
    req_i = 8'h08; tick();
    chk("R5 equal blocked", int'(irq_o), 0);
    mode_i = 2'd1; #1;
    chk("R6 equal passes", int'(irq_o), 1);
    chk("R6 winner", int'(win_o), 3);
    pulse_ack(); pulse_eoi();
    mode_i = 2'd0; req_i = 8'h00; tick();

    // R3: masked level loses but stays pending
    mask_i = 8'h01; req_i = 8'h03; tick();
    chk("R3 masked loses", int'(win_o), 1);
    chk("R3 still pending", int'(irr_o[0]), 1);
    mask_i = 8'h0F; #1;
    chk("R3 all masked", int'(irq_o), 0);
    mask_i = 8'h00; #1;
    chk("R4 unmasked wins", int'(win_o), 0);
    pulse_ack();
    pulse_ack();                    // level 1 behind level 0: ignored
    chk("R7 ack ignored", int'(isr_o), 8'h01);
    pulse_eoi(); pulse_ack(); pulse_eoi();
    req_i = 8'h00; tick();

    // R9: automatic rotation
    mode_i = 2'd2;
    req_i = 8'h01; tick();
    pulse_ack(); pulse_eoi();
    req_i = 8'h00; tick();
    req_i = 8'h11; tick();
    chk("R9 after 0 retired", int'(win_o), 4);
    pulse_ack(); pulse_eoi();
    req_i = 8'h00; tick();
    req_i = 8'h21; tick();
    chk("R9 after 4 retired", int'(win_o), 5);
    pulse_ack(); pulse_eoi(); pulse_ack(); pulse_eoi();
    req_i = 8'h00; tick();

    // R10: programmed rotation
    mode_i = 2'd3; low_lvl_i = 3'd2;
    req_i = 8'h0E; tick();
    chk("R10 low 2", int'(win_o), 3);
    low_lvl_i = 3'd6; #1;
    chk("R10 low 6", int'(win_o), 1);
    low_lvl_i = 3'd0; #1;
    chk("R10 low 0", int'(win_o), 1);
    req_i = 8'h00; tick();

    // constrained random with fixed seed
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 12; seg++) begin
      mode_i     = 2'(seg % 4);
      low_lvl_i  = 3'($urandom);
      lvl_sens_i = 8'($urandom & $urandom);
      for (int c = 0; c < 200; c++) begin
        req_i  = req_i ^ 8'($urandom & $urandom & $urandom);
        mask_i = 8'($urandom & $urandom & $urandom);
        ack_i  = ($urandom % 4) == 0;
        eoi_i  = ($urandom % 5) == 0;
        if (mode_i == 2'd3 && ($urandom % 16) == 0) low_lvl_i = 3'($urandom);
        tick();
      end
    end
    ack_i = 0; eoi_i = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule